// File: doc/BRIEF.md
# Loop Counter and Data Latch Unit

This unit keeps the iteration counter and the wide data latch that a sequencer stage uses while it runs repeated instruction groups. Each cycle it receives one decoded operation, and that operation can change the counter, the latch, or neither. The counter can be loaded in three ways: from a literal, from the low bits of the latch, or by a step down that stops at zero and never wraps. The latch takes full loads and partial loads. A partial load writes only its own slice of the latch and leaves every other bit as it was. A high-part load also sets a sign flag.

A separate kill strobe comes from annihilation handling. It forces the counter to zero and takes priority over any counter update in the same cycle. The unit drives out the counter, a combinational zero flag, the latch and the sign flag. Fetch and the instruction queue are outside this unit.

Top module: `loop_data_unit`

## Requirements
- R1: When rst_ni is low, the counter, the latch and the sign flag are all cleared.
- R2: Operation code 1 (counter load) with source 2'b00 writes the old counter minus 1 into the counter. If the old counter is 0, it stays 0.
- R3: Counter load with source 2'b01 copies latch bits [5:0] into the counter.
- R4: Counter load with source 2'b10 or 2'b11 writes the 6-bit literal lit_i[5:0] into the counter.
- R5: Operation code 4 (high load) writes lit_i[18:1] into latch bits [37:20] and writes lit_i[18] into the sign flag. Latch bits [19:0] keep their values.
- R6: Operation code 3 (low load) writes lit_i[19:0] into latch bits [19:0]. Bits [37:20] and the sign flag keep their values.
- R7: Operation code 2 (full load) writes lit_i zero-extended into the whole latch, and the sign flag is cleared.
- R8: A high kill_i makes the counter 0 on the next cycle, whatever the operation in that cycle. Latch operations in that cycle still take effect.
- R9: zero_o is high exactly when the counter is 0, with no register in between.
- R10: Operation code 0 (no-op), and any operation while op_valid_i is low, leaves the counter, the latch and the sign flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation valid |
| op_i | input | 3 | Operation code |
| src_i | input | 2 | Source select for a counter load |
| lit_i | input | 20 | Literal field |
| kill_i | input | 1 | Clears the counter |
| count_o | output | 6 | Counter value |
| zero_o | output | 1 | High when the counter is 0 |
| latch_o | output | 38 | Data latch |
| sign_o | output | 1 | Sign flag |

## Verification
The bench first targets a step down from 0. A design that wraps would show 63 and start an iteration that should never happen. It also drives a kill in the same cycle as a counter load; if the load wins, a group that should have been annihilated keeps running. Partial loads are tried over random latch contents, so a write that spills outside its slice shows up as corrupted neighbouring bits. Operations with op_valid_i low must leave every output unchanged.

// File: rtl/loop_data_pkg.sv
package loop_data_pkg;
  localparam int unsigned CNT_W = 6;
  localparam int unsigned LAT_W = 38;
  localparam int unsigned LIT_W = 20;
  localparam int unsigned HI_LSB = 20;
  localparam int unsigned HI_W = LAT_W - HI_LSB;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_CNT  = 3'd1,
    OP_FULL = 3'd2,
    OP_LO   = 3'd3,
    OP_HI   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SRC_DEC = 2'b00,
    SRC_LAT = 2'b01,
    SRC_LIT = 2'b10,
    SRC_LT2 = 2'b11
  } src_e;
endpackage

// File: rtl/ld_op_decode.sv
module ld_op_decode
  import loop_data_pkg::*;
(
  input  logic       op_valid_i,
  input  logic [2:0] op_i,
  output logic       cnt_ld_o,
  output logic       full_ld_o,
  output logic       lo_ld_o,
  output logic       hi_ld_o
);
  always_comb begin
    cnt_ld_o  = 1'b0;
    full_ld_o = 1'b0;
    lo_ld_o   = 1'b0;
    hi_ld_o   = 1'b0;
    if (op_valid_i) begin
      unique case (op_e'(op_i))
        OP_CNT:  cnt_ld_o  = 1'b1;
        OP_FULL: full_ld_o = 1'b1;
        OP_LO:   lo_ld_o   = 1'b1;
        OP_HI:   hi_ld_o   = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ld_counter.sv
module ld_counter
  import loop_data_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [1:0]   src_i,
  input  logic [W-1:0] lat_bits_i,
  input  logic [W-1:0] lit_i,
  input  logic         kill_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d, dec;

  // saturating step down
  assign dec = (cnt_q == '0) ? '0 : cnt_q - W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i) begin
      unique case (src_e'(src_i))
        SRC_DEC: cnt_d = dec;
        SRC_LAT: cnt_d = lat_bits_i;
        default: cnt_d = lit_i;
      endcase
    end
    if (kill_i) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ld_latch.sv
module ld_latch
  import loop_data_pkg::*;
#(
  parameter int unsigned W   = LAT_W,
  parameter int unsigned LW  = LIT_W,
  parameter int unsigned SPL = HI_LSB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          full_i,
  input  logic          lo_i,
  input  logic          hi_i,
  input  logic [LW-1:0] lit_i,
  output logic [W-1:0]  lat_o,
  output logic          sign_o
);
  localparam int unsigned HW = W - SPL;

  logic [SPL-1:0] lo_q, lo_d;
  logic [HW-1:0]  hi_q, hi_d;
  logic           s_q, s_d;
  logic [W-1:0]   full_val;

  assign full_val = W'(lit_i);

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    s_d  = s_q;
    if (full_i) begin
      lo_d = full_val[SPL-1:0];
      hi_d = full_val[W-1:SPL];
      s_d  = 1'b0;
    end else if (lo_i) begin
      lo_d = lit_i[SPL-1:0];
    end else if (hi_i) begin
      hi_d = lit_i[HW:1];
      s_d  = lit_i[HW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
      s_q  <= 1'b0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      s_q  <= s_d;
    end
  end

  assign lat_o  = {hi_q, lo_q};
  assign sign_o = s_q;
endmodule

// File: rtl/loop_data_unit.sv
module loop_data_unit
  import loop_data_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [2:0]       op_i,
  input  logic [1:0]       src_i,
  input  logic [LIT_W-1:0] lit_i,
  input  logic             kill_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o,
  output logic [LAT_W-1:0] latch_o,
  output logic             sign_o
);
  logic cnt_ld, full_ld, lo_ld, hi_ld;

  ld_op_decode u_dec (
    .op_valid_i(op_valid_i), .op_i(op_i),
    .cnt_ld_o(cnt_ld), .full_ld_o(full_ld), .lo_ld_o(lo_ld), .hi_ld_o(hi_ld)
  );

  ld_latch #(.W(LAT_W), .LW(LIT_W), .SPL(HI_LSB)) u_lat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .full_i(full_ld), .lo_i(lo_ld), .hi_i(hi_ld),
    .lit_i(lit_i), .lat_o(latch_o), .sign_o(sign_o)
  );

  ld_counter #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(cnt_ld), .src_i(src_i),
    .lat_bits_i(latch_o[CNT_W-1:0]), .lit_i(lit_i[CNT_W-1:0]),
    .kill_i(kill_i), .cnt_o(count_o)
  );

  assign zero_o = (count_o == '0);
endmodule

// File: rtl/loop_data_chk.sv
module loop_data_chk
  import loop_data_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic [2:0]       op_i,
  input logic [1:0]       src_i,
  input logic [LIT_W-1:0] lit_i,
  input logic             kill_i,
  input logic [CNT_W-1:0] count_o,
  input logic             zero_o,
  input logic [LAT_W-1:0] latch_o,
  input logic             sign_o
);
  logic cl;
  assign cl = op_valid_i && op_i == 3'd1;

  AST_KILL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> count_o == '0); // R8
  AST_DEC_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl && !kill_i && src_i == 2'b00 && count_o == '0) |=> count_o == '0); // R2
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl && !kill_i && src_i == 2'b00 && count_o != '0) |=> count_o == $past(count_o) - 6'd1); // R2
  AST_LAT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl && !kill_i && src_i == 2'b01) |=> count_o == $past(latch_o[CNT_W-1:0])); // R3
  AST_LIT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl && !kill_i && src_i[1]) |=> count_o == $past(lit_i[CNT_W-1:0])); // R4
  AST_HI_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd4) |=> latch_o[19:0] == $past(latch_o[19:0])
      && sign_o == $past(lit_i[18])); // R5
  AST_LO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd3) |=> latch_o[37:20] == $past(latch_o[37:20])
      && $stable(sign_o)); // R6
  AST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_valid_i && !kill_i) |=> $stable(count_o) && $stable(latch_o) && $stable(sign_o)); // R10
  always_comb if (rst_ni) AST_ZERO_FLAG: assert (zero_o == (count_o == '0)); // R9
endmodule

bind loop_data_unit loop_data_chk u_chk (.*);

// File: tb/sim_loop_data_unit.sv
module sim_loop_data_unit;
  logic clk = 0, rst_ni = 0;
  logic op_valid_i = 0, kill_i = 0;
  logic [2:0] op_i = 0;
  logic [1:0] src_i = 0;
  logic [19:0] lit_i = 0;
  logic [5:0] count_o;
  logic zero_o, sign_o;
  logic [37:0] latch_o;

  int n_chk = 0, n_bad = 0;
  logic [5:0] m_cnt;
  logic [37:0] m_lat;
  logic m_s;

  always #10 clk = ~clk;

  loop_data_unit u0 (.clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid_i),
    .op_i(op_i), .src_i(src_i), .lit_i(lit_i), .kill_i(kill_i),
    .count_o(count_o), .zero_o(zero_o), .latch_o(latch_o), .sign_o(sign_o));

  function automatic logic [5:0] f_cnt(logic [5:0] c, logic [37:0] l, logic v,
      logic [2:0] o, logic [1:0] s, logic [19:0] t, logic k);
    if (k) return 6'd0;
    if (!v || o != 3'd1) return c;
    case (s)
      2'b00: return (c == 0) ? 6'd0 : c - 6'd1;
      2'b01: return l[5:0];
      default: return t[5:0];
    endcase
  endfunction

  task automatic chk(string r);
    n_chk++;
    if (count_o !== m_cnt || latch_o !== m_lat || sign_o !== m_s || zero_o !== (m_cnt == 0)) begin
      n_bad++;
      $display("FAIL %s: cnt=%0d lat=%h s=%b z=%b exp cnt=%0d lat=%h s=%b z=%b", r,
        count_o, latch_o, sign_o, zero_o, m_cnt, m_lat, m_s, m_cnt == 0);
    end
  endtask

  task automatic step(logic v, logic [2:0] o, logic [1:0] s, logic [19:0] t, logic k, string r);
    op_valid_i = v; op_i = o; src_i = s; lit_i = t; kill_i = k;
    @(posedge clk);
    m_cnt = f_cnt(m_cnt, m_lat, v, o, s, t, k);
    if (v && o == 3'd2) begin m_lat = {18'd0, t}; m_s = 0; end
    else if (v && o == 3'd3) m_lat[19:0] = t;
    else if (v && o == 3'd4) begin m_lat[37:20] = t[18:1]; m_s = t[18]; end
    #5;
    chk(r);
  endtask

  initial begin
    m_cnt = 0; m_lat = 0; m_s = 0;
    #25; chk("R1");
    rst_ni = 1;
    @(negedge clk);
    step(1, 1, 2'b00, 0, 0, "R2 sat at zero");
    step(1, 1, 2'b10, 20'h3f, 0, "R4 literal 63");
    step(1, 1, 2'b00, 0, 0, "R2 step");
    step(1, 4, 0, 20'h7ffff, 0, "R5 high with sign");
    step(1, 3, 0, 20'h00005, 0, "R6 low");
    step(1, 1, 2'b01, 0, 0, "R3 from latch");
    step(1, 1, 2'b11, 20'h12, 1, "R8 kill beats load");
    step(1, 4, 0, 20'h2aaaa, 1, "R8 latch still written");
    step(0, 2, 0, 20'hfffff, 0, "R10 invalid");
    step(1, 0, 0, 20'hfffff, 0, "R10 nop");
    step(1, 2, 0, 20'habcde, 0, "R7 full");
    step(1, 1, 2'b01, 0, 0, "R3 from latch");
    repeat (6) step(1, 1, 2'b00, 0, 0, "R2 R9 count down");
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 7) != 0, 3'($urandom_range(0, 4)), 2'($urandom),
           20'($urandom), $urandom_range(0, 15) == 0, "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    rst_ni = 0; m_cnt = 0; m_lat = 0; m_s = 0;
    #5; chk("R1 async");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    process::self();
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule